// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block sits between a UART transmit path and a half-duplex RS-485 transceiver. It watches the transmit FIFO (empty flag) and the serializer (busy flag) and drives the transceiver's driver-enable line. When data appears while the line is released, it asserts the direction output at once. It then holds back the serializer through a start permission (`tx_go_o`) for a programmed number of bit times, which gives the transceiver time to wake up. Once the FIFO is empty and the last stop bit has left the shifter, it keeps the driver enabled for a programmed number of bit times, so that the tail of the frame can travel down long cables. Only then does it release the line.

The same block also produces the forced parity value for multidrop networks. While multidrop marking is on, the first byte of a burst is sent with its parity bit forced to 1, which marks it as an address. The bytes after it carry parity 0. No stall and no software parity switching is needed between them. Bit-time pacing comes from a one-cycle tick supplied by the baud generator.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset the direction output sits at its inactive level. `parity_force_o` and `parity_bit_o` are 0 while multidrop marking is off.
- R2: While `auto_en_i` is 0, `tx_go_o` is 1. From the cycle after `auto_en_i` falls, the direction output is inactive.
- R3: With `auto_en_i`=1 and the line released, a non-empty FIFO asserts the direction output one clock later. `tx_go_o` then stays 0 for exactly `setup_bits_i` bit ticks and rises on the clock of the last one. A setup of 0 raises `tx_go_o` together with the direction output.
- R4: In the active phase, once the FIFO is empty and the serializer is not busy, `tx_go_o` drops. The direction output stays asserted for exactly `hold_bits_i` bit ticks and then releases. A hold of 0 releases it on the next clock.
- R5: If the FIFO becomes non-empty or the serializer busy during the hold phase, the direction output never releases and `tx_go_o` returns one clock later without a new setup delay. This holds even when that happens in the same cycle as the final hold tick.
- R6: `dir_pol_i`=1 makes the asserted level of `dir_o` high. `dir_pol_i`=0 makes it low.
- R7: `parity_force_o` equals `mdrop_en_i`.
- R8: After `mdrop_en_i` rises, the first byte popped (`byte_pop_i`, the serializer samples `parity_bit_o` in that cycle) sees `parity_bit_o`=1. This holds even if the pop falls in the enabling cycle. The following pops see 0.
- R9: The address mark is re-armed after any cycle in which the transmit path is idle (FIFO empty and serializer not busy), or by a `rearm_i` pulse. A pop in the same cycle as `rearm_i` uses the mark state from before the pulse, and the next pop sees 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per bit time from the baud generator |
| auto_en_i | input | 1 | Enables automatic direction control |
| dir_pol_i | input | 1 | Asserted level of `dir_o` (1 = high) |
| setup_bits_i | input | 4 | Bit times between driver enable and first start bit |
| hold_bits_i | input | 4 | Bit times the driver stays enabled after the last stop bit |
| fifo_empty_i | input | 1 | Transmit FIFO empty |
| shift_busy_i | input | 1 | Serializer is shifting a frame |
| tx_go_o | output | 1 | Serializer may start a new frame |
| dir_o | output | 1 | Transceiver driver enable |
| mdrop_en_i | input | 1 | Multidrop address marking on |
| rearm_i | input | 1 | Re-arm address marking for the next byte |
| byte_pop_i | input | 1 | Serializer takes a byte from the FIFO this cycle |
| parity_force_o | output | 1 | Parity bit is forced |
| parity_bit_o | output | 1 | Forced parity value for the byte being popped |

## Verification
Two pairs of events can land on the same clock edge. The first pair is the hold timer's final tick and fresh data arriving; the bench provokes it by arming a one-tick hold and presenting a non-empty FIFO exactly in the cycle that carries the tick. It then judges that the driver enable never drops and that `tx_go_o` returns on the next clock. The second pair is a byte pop coinciding with a re-arm pulse, or with the enabling cycle of marking. There the bench checks the parity seen by the coinciding pop and by the pop after it. Setup and hold lengths are swept over all 256 combinations, with the tick phase drifting between runs.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE   = 2'd0,
    DIR_SETUP  = 2'd1,
    DIR_ACTIVE = 2'd2,
    DIR_HOLD   = 2'd3
  } dir_state_e;
endpackage

// File: rtl/rs485_bit_timer.sv
module rs485_bit_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - ONE;
  end

  assign expire_o = tick_i && !load_i && (cnt_q == ONE);
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         auto_en_i,
  input  logic         data_pend_i,
  input  logic         path_idle_i,
  input  logic [W-1:0] setup_i,
  input  logic [W-1:0] hold_i,
  input  logic         expire_i,
  output logic         load_o,
  output logic [W-1:0] load_val_o,
  output logic         dir_on_o,
  output logic         tx_go_o
);
  dir_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = setup_i;
    unique case (state_q)
      DIR_IDLE: if (data_pend_i) begin
        if (setup_i == '0) state_d = DIR_ACTIVE;
        else begin
          state_d = DIR_SETUP;
          load_o  = 1'b1;
        end
      end
      DIR_SETUP: if (expire_i) state_d = DIR_ACTIVE;
      DIR_ACTIVE: if (path_idle_i) begin
        load_val_o = hold_i;
        if (hold_i == '0) state_d = DIR_IDLE;
        else begin
          state_d = DIR_HOLD;
          load_o  = 1'b1;
        end
      end
      DIR_HOLD: begin
        // new traffic wins over the final hold tick
        if (!path_idle_i)  state_d = DIR_ACTIVE;
        else if (expire_i) state_d = DIR_IDLE;
      end
      default: state_d = DIR_IDLE;
    endcase
    if (!auto_en_i) state_d = DIR_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= DIR_IDLE;
    else         state_q <= state_d;
  end

  assign dir_on_o = (state_q != DIR_IDLE);
  assign tx_go_o  = !auto_en_i || (state_q == DIR_ACTIVE);
endmodule

// File: rtl/rs485_addr_mark.sv
module rs485_addr_mark (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mdrop_en_i,
  input  logic rearm_i,
  input  logic pop_i,
  input  logic path_idle_i,
  output logic parity_force_o,
  output logic parity_bit_o
);
  logic armed_q, en_q, mark;

  // first cycle of enable counts as armed
  assign mark = armed_q || !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      en_q    <= mdrop_en_i;
      armed_q <= mdrop_en_i && (rearm_i || path_idle_i || (mark && !pop_i));
    end
  end

  assign parity_force_o = mdrop_en_i;
  assign parity_bit_o   = mdrop_en_i && mark;
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl #(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic             auto_en_i,
  input  logic             dir_pol_i,
  input  logic [DLY_W-1:0] setup_bits_i,
  input  logic [DLY_W-1:0] hold_bits_i,
  input  logic             fifo_empty_i,
  input  logic             shift_busy_i,
  output logic             tx_go_o,
  output logic             dir_o,
  input  logic             mdrop_en_i,
  input  logic             rearm_i,
  input  logic             byte_pop_i,
  output logic             parity_force_o,
  output logic             parity_bit_o
);
  logic             path_idle, load, expire, dir_on;
  logic [DLY_W-1:0] load_val;

  assign path_idle = fifo_empty_i && !shift_busy_i;

  rs485_bit_timer #(.W(DLY_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .tick_i     (bit_tick_i),
    .expire_o   (expire)
  );

  rs485_dir_fsm #(.W(DLY_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .auto_en_i   (auto_en_i),
    .data_pend_i (!fifo_empty_i),
    .path_idle_i (path_idle),
    .setup_i     (setup_bits_i),
    .hold_i      (hold_bits_i),
    .expire_i    (expire),
    .load_o      (load),
    .load_val_o  (load_val),
    .dir_on_o    (dir_on),
    .tx_go_o     (tx_go_o)
  );

  rs485_addr_mark u_mark (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mdrop_en_i     (mdrop_en_i),
    .rearm_i        (rearm_i),
    .pop_i          (byte_pop_i),
    .path_idle_i    (path_idle),
    .parity_force_o (parity_force_o),
    .parity_bit_o   (parity_bit_o)
  );

  assign dir_o = dir_pol_i ? dir_on : !dir_on;
endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
module rs485_dir_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic auto_en_i,
  input logic fifo_empty_i,
  input logic shift_busy_i,
  input logic tx_go_o,
  input logic dir_on,
  input logic mdrop_en_i,
  input logic rearm_i,
  input logic byte_pop_i,
  input logic parity_bit_o
);
  // R2
  auto_off_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> !dir_on || auto_en_i);

  // R3
  go_needs_driver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && tx_go_o) |-> dir_on);

  // R4
  release_on_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dir_on) |-> $past(!auto_en_i || (fifo_empty_i && !shift_busy_i)));

  // R8
  data_after_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdrop_en_i && byte_pop_i && !rearm_i && !(fifo_empty_i && !shift_busy_i))
      |=> (!parity_bit_o));

  // R9
  rearm_marks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdrop_en_i && rearm_i) |=> (parity_bit_o || !mdrop_en_i));
endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .auto_en_i    (auto_en_i),
  .fifo_empty_i (fifo_empty_i),
  .shift_busy_i (shift_busy_i),
  .tx_go_o      (tx_go_o),
  .dir_on       (dir_on),
  .mdrop_en_i   (mdrop_en_i),
  .rearm_i      (rearm_i),
  .byte_pop_i   (byte_pop_i),
  .parity_bit_o (parity_bit_o)
);

// File: tb/rs485_dir_ctrl_test.sv
module rs485_dir_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, auto_en = 1'b0, pol = 1'b1;
  logic [3:0] setup = '0, hold = '0;
  logic       fempty = 1'b1, busy = 1'b0;
  logic       tx_go, dir;
  logic       md_en = 1'b0, rearm = 1'b0, pop = 1'b0;
  logic       pforce, pbit;

  int checks = 0, errors = 0;
  int tcnt = 0, acc = 0;
  logic pre_on, pre_go, pre_tick, pre_par;

  always #2 clk = ~clk;

  rs485_dir_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .auto_en_i(auto_en),
    .dir_pol_i(pol), .setup_bits_i(setup), .hold_bits_i(hold),
    .fifo_empty_i(fempty), .shift_busy_i(busy), .tx_go_o(tx_go), .dir_o(dir),
    .mdrop_en_i(md_en), .rearm_i(rearm), .byte_pop_i(pop),
    .parity_force_o(pforce), .parity_bit_o(pbit)
  );

  function automatic logic on_now();
    return dir == pol;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: tick every third cycle; counts ticks seen while driver on and go low
  task automatic adv();
    tick = (tcnt == 2);
    tcnt = (tcnt + 1) % 3;
    #1;
    pre_on = on_now(); pre_go = tx_go; pre_tick = tick; pre_par = pbit;
    if (pre_on && !pre_go && pre_tick) acc++;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lim;
    @(negedge clk); @(negedge clk);
    // R1
    chk(dir == 1'b0, "R1 dir idle", dir, 0);
    chk(pforce == 1'b0 && pbit == 1'b0, "R1 parity idle", pbit, 0);
    rst_n = 1'b1;
    adv();
    // R2
    fempty = 1'b0; adv(); adv();
    chk(tx_go == 1'b1, "R2 go while off", tx_go, 1);
    chk(dir == 1'b0, "R2 dir while off", dir, 0);
    fempty = 1'b1; adv();

    // R3 R4 R6 sweep
    for (int s = 0; s < 16; s++) begin
      for (int h = 0; h < 16; h++) begin
        setup = 4'(s); hold = 4'(h); pol = 1'((s + h) % 2);
        auto_en = 1'b1; fempty = 1'b1; busy = 1'b0;
        adv();
        chk(!on_now(), "R6 inactive level", dir, !pol);
        fempty = 1'b0; acc = 0;
        adv();
        chk(on_now(), "R3 driver asserts", dir, pol);
        chk(dir == pol, "R6 active level", dir, pol);
        lim = 0;
        while (!tx_go && lim < 100) begin adv(); lim++; end
        chk(acc == s, "R3 setup ticks", acc, s);
        busy = 1'b1; fempty = 1'b1;
        for (int k = 0; k < 2 + (s % 3); k++) adv();
        busy = 1'b0; acc = 0;
        adv();
        chk(tx_go == 1'b0 || h == 0, "R4 go drops", tx_go, 0);
        lim = 0;
        while (on_now() && lim < 100) begin adv(); lim++; end
        chk(acc == h, "R4 hold ticks", acc, h);
      end
    end

    // R5: data mid-hold
    pol = 1'b1; setup = 4'd2; hold = 4'd5; fempty = 1'b0;
    adv();
    lim = 0; while (!tx_go && lim < 50) begin adv(); lim++; end
    fempty = 1'b1; adv(); adv(); adv(); adv();
    chk(on_now() && !tx_go, "R5 in hold", tx_go, 0);
    fempty = 1'b0; adv();
    chk(on_now() && tx_go, "R5 resume no setup", tx_go, 1);
    // R5: data on the final hold tick
    hold = 4'd1; fempty = 1'b1; adv();
    chk(on_now() && !tx_go, "R5 hold1 entered", tx_go, 0);
    lim = 0; while (tcnt != 2 && lim < 5) begin adv(); lim++; end
    chk(on_now(), "R5 still holding", dir, 1);
    fempty = 1'b0; adv();
    chk(pre_tick == 1'b1, "R5 tick coincided", pre_tick, 1);
    chk(on_now() && tx_go, "R5 coincide keeps driver", dir, 1);
    fempty = 1'b1; hold = 4'd0; adv(); adv();
    chk(!on_now(), "R4 hold zero release", dir, 0);
    // R2 auto off drops driver mid-burst
    setup = 4'd0; fempty = 1'b0; adv();
    chk(on_now(), "R3 setup zero", dir, 1);
    auto_en = 1'b0; adv();
    chk(!on_now() && tx_go, "R2 auto off", dir, 0);

    // R7 R8 R9 multidrop
    busy = 1'b1; fempty = 1'b0;
    adv();
    chk(pforce == 1'b0 && pbit == 1'b0, "R7 force off", pforce, 0);
    md_en = 1'b1; pop = 1'b1; adv();
    chk(pre_par == 1'b1, "R8 first pop in enable cycle", pre_par, 1);
    chk(pforce == 1'b1, "R7 force on", pforce, 1);
    adv();
    chk(pre_par == 1'b0, "R8 second pop data", pre_par, 0);
    pop = 1'b0; adv(); pop = 1'b1; adv();
    chk(pre_par == 1'b0, "R8 third pop data", pre_par, 0);
    pop = 1'b0; busy = 1'b0; fempty = 1'b1; adv();
    busy = 1'b1; fempty = 1'b0; adv();
    pop = 1'b1; adv();
    chk(pre_par == 1'b1, "R9 rearm after idle", pre_par, 1);
    adv();
    chk(pre_par == 1'b0, "R9 data after idle burst", pre_par, 0);
    rearm = 1'b1; adv();
    chk(pre_par == 1'b0, "R9 pop with rearm uses old", pre_par, 0);
    rearm = 1'b0; adv();
    chk(pre_par == 1'b1, "R9 pop after rearm", pre_par, 1);
    pop = 1'b0; rearm = 1'b1; adv(); rearm = 1'b0; adv(); adv();
    pop = 1'b1; adv();
    chk(pre_par == 1'b1, "R9 rearm alone", pre_par, 1);
    pop = 1'b0; md_en = 1'b0; adv();
    chk(pforce == 1'b0 && pbit == 1'b0, "R7 force off again", pbit, 0);
    md_en = 1'b1; adv(); adv();
    chk(pbit == 1'b1, "R8 armed after enable", pbit, 1);
    pop = 1'b1; adv(); adv();
    chk(pre_par == 1'b0, "R8 data after re-enable", pre_par, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule